// File: doc/BRIEF.md
# GPIO pad configuration register bank

This block holds the configuration of one port of general-purpose pins, one bit per pin in most registers. It sets the pin direction, the digital input enable, the analog select, the pull-up and pull-down, the open-drain output type, three drive-strength selects, slew control and the alternate-function select. A further register holds a 4-bit function-mux field for each pin. Software reaches the registers over a plain register bus: a write strobe with address and data, and a combinational read path. The block drives its stored settings straight to the pad control pins.

Some registers form exclusive groups, and the bank keeps them exclusive on every write. Pull-up and pull-down form one group. The three drive selects form another. Writing a 1 for a pin into one member of a group clears that pin's bit in the other members. A per-pin commit-enable input decides which pins a write may change. The bus carries no streaming data, so it has no valid/ready handshake: a write completes on the clock edge at which it is strobed.

Top module: `gpio_padcfg_bank`

## Requirements
- R1: After reset every register reads 0, except digital enable and 2 mA drive, which read all ones. Every pin is then a digital input with no pull, push-pull output and 2 mA drive.
- R2: A write with `bus_wr` high stores `bus_wdata` into the register at `bus_addr` on the next rising clock edge. The same value then reads back and appears on the pad pins. Addresses: 0 direction (1 = output), 1 digital enable, 2 analog select, 3 pull-up, 4 pull-down, 5 open-drain, 6 drive 2 mA, 7 drive 4 mA, 8 drive 8 mA, 9 slew, 10 alternate select, 11 function mux.
- R3: A write changes a pin's bits only where that pin's `commit_en` bit is high. Every other pin keeps its old value in every register.
- R4: When a write stores a 1 into a committed pin's bit of pull-up, that pin's pull-down bit is cleared, and the reverse. The two are never both set for a pin.
- R5: When a write stores a 1 into a committed pin's bit of one drive select, that pin's bits in the other two drive selects are cleared. At most one drive select is set per pin.
- R6: `pad_slew` for a pin is high only when both its slew bit and its 8 mA drive bit are set.
- R7: In the function-mux register, pin n owns bits [4n+3:4n]. `pad_fsel` carries that field when the pin's alternate-select bit is set, and 0 when it is clear.
- R8: Register bits above the pins' width read as 0, and so do addresses 12 to 15.
- R9: Writing 0 into a member of an exclusive group leaves the other members of the group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| commit_en | input | NUM_PINS (8) | Per-pin write enable |
| pad_dir | output | NUM_PINS | Output enable, 1 = output |
| pad_den | output | NUM_PINS | Digital input enable |
| pad_ana | output | NUM_PINS | Analog select |
| pad_pu | output | NUM_PINS | Pull-up enable |
| pad_pd | output | NUM_PINS | Pull-down enable |
| pad_od | output | NUM_PINS | Open-drain output type |
| pad_drv2 | output | NUM_PINS | 2 mA drive select |
| pad_drv4 | output | NUM_PINS | 4 mA drive select |
| pad_drv8 | output | NUM_PINS | 8 mA drive select |
| pad_slew | output | NUM_PINS | Slew control, gated by 8 mA drive |
| pad_alt | output | NUM_PINS | Alternate-function select |
| pad_fsel | output | NUM_PINS*FSEL_W (32) | Per-pin function number, 0 when not alternate |

## Verification
The bench builds the bank with NUM_PINS = 4 and keeps FSEL_W = 4 and DATA_W = 32. With four pins the whole space of data patterns and commit masks (16 × 16) can be swept against every register. Every exclusive-group interaction then occurs for every combination of prior state, written value and commit mask. The 16-bit function-mux field leaves the upper half of the data word unused, so the reads-as-zero behaviour is observable.

// File: rtl/gpio_padcfg_pkg.sv
package gpio_padcfg_pkg;
  localparam int REG_ADDR_W = 4;
  localparam logic [REG_ADDR_W-1:0] REG_DIR   = 4'd0;
  localparam logic [REG_ADDR_W-1:0] REG_DEN   = 4'd1;
  localparam logic [REG_ADDR_W-1:0] REG_ANA   = 4'd2;
  localparam logic [REG_ADDR_W-1:0] REG_PU    = 4'd3;
  localparam logic [REG_ADDR_W-1:0] REG_PD    = 4'd4;
  localparam logic [REG_ADDR_W-1:0] REG_OD    = 4'd5;
  localparam logic [REG_ADDR_W-1:0] REG_DRV2  = 4'd6;
  localparam logic [REG_ADDR_W-1:0] REG_DRV4  = 4'd7;
  localparam logic [REG_ADDR_W-1:0] REG_DRV8  = 4'd8;
  localparam logic [REG_ADDR_W-1:0] REG_SLEW  = 4'd9;
  localparam logic [REG_ADDR_W-1:0] REG_ALT   = 4'd10;
  localparam logic [REG_ADDR_W-1:0] REG_FMUX  = 4'd11;
  localparam int NUM_SINGLE = 6;
endpackage

// File: rtl/gpio_excl_grp.sv
module gpio_excl_grp #(
  parameter int NPINS   = 8,
  parameter int MEMBERS = 1,
  parameter logic [MEMBERS*NPINS-1:0] RST = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [MEMBERS-1:0]       wr_sel,
  input  logic [NPINS-1:0]         wdata,
  input  logic [NPINS-1:0]         commit,
  output logic [MEMBERS*NPINS-1:0] q
);
  localparam int W = MEMBERS * NPINS;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    for (int g = 0; g < MEMBERS; g++) begin
      for (int i = 0; i < NPINS; i++) begin
        if (commit[i] && (|wr_sel)) begin
          if (wr_sel[g])
            q_nxt[g*NPINS+i] = wdata[i];
          else if (wdata[i])
            q_nxt[g*NPINS+i] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/gpio_fmux_reg.sv
module gpio_fmux_reg #(
  parameter int NPINS  = 8,
  parameter int FSEL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [NPINS*FSEL_W-1:0] wdata,
  input  logic [NPINS-1:0]        commit,
  output logic [NPINS*FSEL_W-1:0] q
);
  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q[p*FSEL_W +: FSEL_W] <= '0;
        else if (wr && commit[p])
          q[p*FSEL_W +: FSEL_W] <= wdata[p*FSEL_W +: FSEL_W];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_padcfg_bank.sv
module gpio_padcfg_bank
  import gpio_padcfg_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int FSEL_W   = 4,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]        commit_en,
  output logic [NUM_PINS-1:0]        pad_dir,
  output logic [NUM_PINS-1:0]        pad_den,
  output logic [NUM_PINS-1:0]        pad_ana,
  output logic [NUM_PINS-1:0]        pad_pu,
  output logic [NUM_PINS-1:0]        pad_pd,
  output logic [NUM_PINS-1:0]        pad_od,
  output logic [NUM_PINS-1:0]        pad_drv2,
  output logic [NUM_PINS-1:0]        pad_drv4,
  output logic [NUM_PINS-1:0]        pad_drv8,
  output logic [NUM_PINS-1:0]        pad_slew,
  output logic [NUM_PINS-1:0]        pad_alt,
  output logic [NUM_PINS*FSEL_W-1:0] pad_fsel
);
  localparam int FMUX_W = NUM_PINS * FSEL_W;
  localparam logic [ADDR_W-1:0] SINGLE_ADDR [NUM_SINGLE] =
    '{ADDR_W'(REG_DIR), ADDR_W'(REG_DEN), ADDR_W'(REG_ANA),
      ADDR_W'(REG_OD), ADDR_W'(REG_SLEW), ADDR_W'(REG_ALT)};

  logic [NUM_PINS-1:0]   wbits;
  logic [NUM_PINS-1:0]   single_q [NUM_SINGLE];
  logic [2*NUM_PINS-1:0] pull_q;
  logic [3*NUM_PINS-1:0] drv_q;
  logic [FMUX_W-1:0]     fmux_q;
  logic [NUM_PINS-1:0]   slew_raw;

  assign wbits = bus_wdata[NUM_PINS-1:0];

  // Plain one-bit-per-pin registers; digital enable resets to all ones.
  generate
    for (genvar k = 0; k < NUM_SINGLE; k++) begin : g_single
      gpio_excl_grp #(
        .NPINS(NUM_PINS), .MEMBERS(1),
        .RST((k == 1) ? {NUM_PINS{1'b1}} : {NUM_PINS{1'b0}})
      ) i_reg (
        .clk(clk), .rst_n(rst_n),
        .wr_sel(bus_wr && (bus_addr == SINGLE_ADDR[k])),
        .wdata(wbits), .commit(commit_en), .q(single_q[k])
      );
    end
  endgenerate

  // Pull group: member 0 pull-up, member 1 pull-down.
  gpio_excl_grp #(.NPINS(NUM_PINS), .MEMBERS(2), .RST('0)) i_pull (
    .clk(clk), .rst_n(rst_n),
    .wr_sel({bus_wr && (bus_addr == ADDR_W'(REG_PD)),
             bus_wr && (bus_addr == ADDR_W'(REG_PU))}),
    .wdata(wbits), .commit(commit_en), .q(pull_q)
  );

  // Drive group: members 2 mA, 4 mA, 8 mA; 2 mA resets set.
  gpio_excl_grp #(
    .NPINS(NUM_PINS), .MEMBERS(3),
    .RST({{(2*NUM_PINS){1'b0}}, {NUM_PINS{1'b1}}})
  ) i_drive (
    .clk(clk), .rst_n(rst_n),
    .wr_sel({bus_wr && (bus_addr == ADDR_W'(REG_DRV8)),
             bus_wr && (bus_addr == ADDR_W'(REG_DRV4)),
             bus_wr && (bus_addr == ADDR_W'(REG_DRV2))}),
    .wdata(wbits), .commit(commit_en), .q(drv_q)
  );

  gpio_fmux_reg #(.NPINS(NUM_PINS), .FSEL_W(FSEL_W)) i_fmux (
    .clk(clk), .rst_n(rst_n),
    .wr(bus_wr && (bus_addr == ADDR_W'(REG_FMUX))),
    .wdata(bus_wdata[FMUX_W-1:0]), .commit(commit_en), .q(fmux_q)
  );

  assign pad_dir  = single_q[0];
  assign pad_den  = single_q[1];
  assign pad_ana  = single_q[2];
  assign pad_od   = single_q[3];
  assign slew_raw = single_q[4];
  assign pad_alt  = single_q[5];
  assign pad_pu   = pull_q[NUM_PINS-1:0];
  assign pad_pd   = pull_q[2*NUM_PINS-1:NUM_PINS];
  assign pad_drv2 = drv_q[NUM_PINS-1:0];
  assign pad_drv4 = drv_q[2*NUM_PINS-1:NUM_PINS];
  assign pad_drv8 = drv_q[3*NUM_PINS-1:2*NUM_PINS];
  assign pad_slew = slew_raw & pad_drv8;

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_fsel
      assign pad_fsel[p*FSEL_W +: FSEL_W] =
        pad_alt[p] ? fmux_q[p*FSEL_W +: FSEL_W] : '0;
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(REG_DIR):  bus_rdata[NUM_PINS-1:0] = pad_dir;
      ADDR_W'(REG_DEN):  bus_rdata[NUM_PINS-1:0] = pad_den;
      ADDR_W'(REG_ANA):  bus_rdata[NUM_PINS-1:0] = pad_ana;
      ADDR_W'(REG_PU):   bus_rdata[NUM_PINS-1:0] = pad_pu;
      ADDR_W'(REG_PD):   bus_rdata[NUM_PINS-1:0] = pad_pd;
      ADDR_W'(REG_OD):   bus_rdata[NUM_PINS-1:0] = pad_od;
      ADDR_W'(REG_DRV2): bus_rdata[NUM_PINS-1:0] = pad_drv2;
      ADDR_W'(REG_DRV4): bus_rdata[NUM_PINS-1:0] = pad_drv4;
      ADDR_W'(REG_DRV8): bus_rdata[NUM_PINS-1:0] = pad_drv8;
      ADDR_W'(REG_SLEW): bus_rdata[NUM_PINS-1:0] = slew_raw;
      ADDR_W'(REG_ALT):  bus_rdata[NUM_PINS-1:0] = pad_alt;
      ADDR_W'(REG_FMUX): bus_rdata[FMUX_W-1:0]   = fmux_q;
      default:           bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_padcfg_chk.sv
module gpio_padcfg_chk
  import gpio_padcfg_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] commit_en,
  input logic [NUM_PINS-1:0] pad_dir,
  input logic [NUM_PINS-1:0] pad_den,
  input logic [NUM_PINS-1:0] pad_ana,
  input logic [NUM_PINS-1:0] pad_pu,
  input logic [NUM_PINS-1:0] pad_pd,
  input logic [NUM_PINS-1:0] pad_od,
  input logic [NUM_PINS-1:0] pad_drv2,
  input logic [NUM_PINS-1:0] pad_drv4,
  input logic [NUM_PINS-1:0] pad_drv8,
  input logic [NUM_PINS-1:0] pad_alt
);
  logic [10*NUM_PINS-1:0] state;
  assign state = {pad_dir, pad_den, pad_ana, pad_pu, pad_pd, pad_od,
                  pad_drv2, pad_drv4, pad_drv8, pad_alt};

  // R4
  pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  // R5
  drive_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_drv2 & pad_drv4) | (pad_drv2 & pad_drv8) | (pad_drv4 & pad_drv8)) == '0);

  // R3
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state ^ $past(state)) & ~{10{$past(commit_en)}}) == '0);

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(REG_DIR) && (&commit_en))
      |=> pad_dir == $past(bus_wdata[NUM_PINS-1:0]));

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(REG_FMUX)) |-> (bus_rdata >> NUM_PINS) == '0);
endmodule

bind gpio_padcfg_bank gpio_padcfg_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .commit_en(commit_en),
  .pad_dir(pad_dir), .pad_den(pad_den), .pad_ana(pad_ana),
  .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_od(pad_od),
  .pad_drv2(pad_drv2), .pad_drv4(pad_drv4), .pad_drv8(pad_drv8),
  .pad_alt(pad_alt)
);

// File: tb/test_gpio_padcfg_bank.sv
`timescale 1ns/10ps
module test_gpio_padcfg_bank;
  localparam int NP = 4;
  localparam int FW = 4;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NREG = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NP-1:0] commit_en = '0;
  logic [NP-1:0] pad_dir, pad_den, pad_ana, pad_pu, pad_pd, pad_od;
  logic [NP-1:0] pad_drv2, pad_drv4, pad_drv8, pad_slew, pad_alt;
  logic [NP*FW-1:0] pad_fsel;

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] m [NREG];

  always #2 clk = ~clk;

  gpio_padcfg_bank #(.NUM_PINS(NP), .FSEL_W(FW), .ADDR_W(AW), .DATA_W(DW)) i_gpio_padcfg_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .commit_en(commit_en),
    .pad_dir(pad_dir), .pad_den(pad_den), .pad_ana(pad_ana), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_od(pad_od), .pad_drv2(pad_drv2), .pad_drv4(pad_drv4),
    .pad_drv8(pad_drv8), .pad_slew(pad_slew), .pad_alt(pad_alt), .pad_fsel(pad_fsel)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int a);
    if (a == 3 || a == 4) return "R4";
    if (a >= 6 && a <= 8) return "R5";
    if (a == 11) return "R7";
    return "R2";
  endfunction

  // Bench model of a write, built from the requirements.
  task automatic model_write(input int a, input logic [DW-1:0] wd, input logic [NP-1:0] c);
    for (int i = 0; i < NP; i++) begin
      if (c[i]) begin
        if (a == 11) begin
          m[11][i*FW +: FW] = wd[i*FW +: FW];
        end else if (a < NREG) begin
          m[a][i] = wd[i];
          if (wd[i]) begin
            if (a == 3) m[4][i] = 1'b0;
            if (a == 4) m[3][i] = 1'b0;
            if (a >= 6 && a <= 8)
              for (int o = 6; o <= 8; o++) if (o != a) m[o][i] = 1'b0;
          end
        end
      end
    end
  endtask

  task automatic bus_write(input int a, input logic [DW-1:0] wd, input logic [NP-1:0] c);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = wd; commit_en = c;
    @(negedge clk);
    bus_wr = 1'b0; commit_en = '0;
    model_write(a, wd, c);
  endtask

  task automatic verify(input string ctx);
    logic [NP*FW-1:0] ef;
    for (int a = 0; a < 16; a++) begin
      bus_addr = AW'(a);
      #1;
      if (a < NREG) begin
        check((ctx == "") ? tag_of(a) : ctx, {16'h0, bus_rdata[15:0]}, {16'h0, m[a][15:0]});
        check("R8", {16'h0, bus_rdata[31:16]}, 32'h0);
      end else begin
        check("R8", bus_rdata, 32'h0);
      end
    end
    check((ctx == "") ? "R2" : ctx, 32'(pad_dir), m[0] & 32'hF);
    check((ctx == "") ? "R2" : ctx, 32'(pad_den), m[1] & 32'hF);
    check((ctx == "") ? "R4" : ctx, 32'({pad_pd, pad_pu}), ((m[4] & 32'hF) << 4) | (m[3] & 32'hF));
    check((ctx == "") ? "R5" : ctx, 32'({pad_drv8, pad_drv4, pad_drv2}),
          ((m[8] & 32'hF) << 8) | ((m[7] & 32'hF) << 4) | (m[6] & 32'hF));
    check("R6", 32'(pad_slew), m[9] & m[8] & 32'hF);
    for (int i = 0; i < NP; i++) ef[i*FW +: FW] = m[10][i] ? m[11][i*FW +: FW] : '0;
    check("R7", 32'(pad_fsel), 32'(ef));
  endtask

  initial begin
    for (int a = 0; a < NREG; a++) m[a] = '0;
    m[1] = 32'hF;
    m[6] = 32'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    verify("R1");

    // Exhaustive sweep: every register, data pattern and commit mask.
    for (int a = 0; a < NREG; a++)
      for (int d = 0; d < 16; d++)
        for (int c = 0; c < 16; c++) begin
          logic [DW-1:0] wd;
          if (a == 11) wd = {16'hBEEF, 16'((d * 16'h1357 + c * 16'h00F1))};
          else         wd = {28'hBEEF5A3, 4'(d)};
          bus_write(a, wd, NP'(c));
          verify("");
        end

    // R3: no commit, nothing changes
    bus_write(0, 32'hF, 4'h0); verify("R3");
    bus_write(11, 32'hFFFF, 4'h0); verify("R3");

    // R9: zero write into one group member keeps the others
    bus_write(4, 32'hF, 4'hF);
    bus_write(3, 32'h0, 4'hF);
    check("R9", 32'(pad_pd), 32'hF);
    bus_write(8, 32'hF, 4'hF);
    bus_write(7, 32'h0, 4'hF);
    bus_write(6, 32'h0, 4'hF);
    check("R9", 32'(pad_drv8), 32'hF);
    verify("R9");

    // R6: slew only with 8 mA
    bus_write(9, 32'hF, 4'hF);
    check("R6", 32'(pad_slew), 32'hF);
    bus_write(6, 32'h5, 4'hF);
    check("R6", 32'(pad_slew), 32'hA);

    // R7: field positions per pin
    bus_write(11, 32'h4321, 4'hF);
    bus_write(10, 32'h6, 4'hF);
    check("R7", 32'(pad_fsel), 32'h0320);
    verify("R7");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule